// File: doc/BRIEF.md
# Boot-Time Port Option Loader

This block runs once after every reset release. It holds the processor and keeps every port in a safe state. It waits a programmable number of cycles, then reads three configuration bytes from a reserved window at the top of program memory. From those bytes it decodes per-bit pad options for three 8-bit port groups: pull-up enables and output-type selects (CMOS or open drain). The processor may start fetching from address 0 only once the third byte has been captured.

The memory port is a fixed-latency synchronous read. The block raises `rom_rd` with an address, and the memory must present the byte on `rom_data` exactly one clock later. There is no back-pressure on this port: the memory cannot stall the block, and the block never holds a request longer than one cycle. A reset at any point clears every decoded option and starts the sequence again from the wait phase.

`cpu_run` is a level that tells the processor it may execute. `load_done` is a single-cycle pulse on the same edge. Until that edge, every pull-up and every output-type select is forced to zero and `port_hold` keeps all pads in input mode.

Top module: `boot_opt_loader`

## Requirements
- R1: While `rst_n` is low, `cpu_run`, `load_done`, `rom_rd` and all of `p0_pu`, `p0_cmos`, `p1_pu`, `p1_cmos`, `p7_pu` are 0, and `port_hold` is 1.
- R2: After `rst_n` rises, `rom_rd` stays low for the first WAIT_CYCLES-1 clock edges. It first goes high just after edge WAIT_CYCLES.
- R3: Three reads are issued on consecutive cycles at addresses OPT_BASE, OPT_BASE+1 and OPT_BASE+2, with a default OPT_BASE of 15'h7F00. No read is issued anywhere else.
- R4: The byte for each read is taken from `rom_data` exactly one cycle after its request.
- R5: For each bit i of the byte at OPT_BASE: a 1 sets `p0_pu[i]` and `p0_cmos[i]` to 1 (pull-up with CMOS drive), and a 0 sets both to 0 (no pull-up, open drain).
- R6: Bit i of the byte at OPT_BASE+1 sets `p1_cmos[i]` (1 = CMOS, 0 = open drain). Once running, `p1_pu` follows the software input `p1_sw_pu`.
- R7: Bit i of the byte at OPT_BASE+2 sets `p7_pu[i]` (1 = pull-up fitted).
- R8: Until `cpu_run` is 1, all pull-up and output-type outputs are 0 and `port_hold` is 1, whatever `p1_sw_pu` holds.
- R9: `cpu_run` rises on edge WAIT_CYCLES+4 after reset release and stays high until the next reset. `load_done` is high for exactly that one cycle.
- R10: Asserting `rst_n` at any point, including mid-load, clears all options at once. The full sequence then restarts with its full wait.
- R11: No read is issued once `cpu_run` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_rd | output | 1 | Read request to program memory |
| rom_addr | output | ADDR_W | Read address |
| rom_data | input | PORT_W | Read data, valid one cycle after `rom_rd` |
| p1_sw_pu | input | PORT_W | Software pull-up request for port 1 |
| p0_pu | output | PORT_W | Port 0 pull-up enables |
| p0_cmos | output | PORT_W | Port 0 output type (1 = CMOS) |
| p1_pu | output | PORT_W | Port 1 pull-up enables |
| p1_cmos | output | PORT_W | Port 1 output type (1 = CMOS) |
| p7_pu | output | PORT_W | Port 7 pull-up enables |
| port_hold | output | 1 | Pads held in input mode with outputs off |
| cpu_run | output | 1 | Processor may execute from address 0 |
| load_done | output | 1 | One-cycle pulse when loading ends |

## Verification
Two events can land on the same cycle: the capture of the last option byte together with the release of the processor, and an asynchronous reset. The bench asserts reset in the cycle where the final byte is in flight and again during the wait phase. After each reset it requires every output to be cleared at once. It then requires the next load to take the full wait again and to decode the new bytes, not the old ones. A second overlap is the software pull-up request for port 1, which is held high through the whole load. That request is judged to reach `p1_pu` only from the run edge onward.

// File: rtl/boot_opt_pkg.sv
package boot_opt_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DRAIN = 2'd2,
    ST_RUN   = 2'd3
  } boot_state_e;

  localparam int unsigned OPT_SLOTS = 3;
  localparam int unsigned SLOT_P0   = 0;
  localparam int unsigned SLOT_P1   = 1;
  localparam int unsigned SLOT_P7   = 2;
endpackage

// File: rtl/boot_wait_timer.sv
module boot_wait_timer #(
  parameter int unsigned WAIT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  output logic expired
);
  localparam int unsigned CNT_W = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expired = count_en && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (count_en && (cnt_q != LAST)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/boot_fetch_seq.sv
module boot_fetch_seq
  import boot_opt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 15,
  parameter logic [ADDR_W-1:0] OPT_BASE = 15'h7F00,
  parameter int unsigned SLOT_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wait_expired,
  output logic              wait_en,
  output logic              rom_rd,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              cap_en,
  output logic [SLOT_W-1:0] cap_slot,
  output logic              run,
  output logic              done_pulse
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(OPT_SLOTS - 1);

  boot_state_e       state_q, state_d;
  logic [SLOT_W-1:0] slot_q;
  logic              rd_q;
  logic [SLOT_W-1:0] slot_pipe_q;
  logic              run_q;
  logic              done_q;

  assign wait_en  = (state_q == ST_WAIT);
  assign rom_rd   = (state_q == ST_FETCH);
  assign rom_addr = OPT_BASE + ADDR_W'(slot_q);
  assign cap_en   = rd_q;
  assign cap_slot = slot_pipe_q;
  assign run      = run_q;
  assign done_pulse = done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT:  if (wait_expired) state_d = ST_FETCH;
      ST_FETCH: if (slot_q == LAST_SLOT) state_d = ST_DRAIN;
      ST_DRAIN: state_d = ST_RUN;
      ST_RUN:   state_d = ST_RUN;
      default:  state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_WAIT;
      slot_q      <= '0;
      rd_q        <= 1'b0;
      slot_pipe_q <= '0;
      run_q       <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      rd_q        <= rom_rd;
      slot_pipe_q <= slot_q;
      if (rom_rd && (slot_q != LAST_SLOT)) begin
        slot_q <= slot_q + 1'b1;
      end
      done_q <= (state_q == ST_DRAIN);
      if (state_q == ST_DRAIN) begin
        run_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/boot_opt_regs.sv
module boot_opt_regs
  import boot_opt_pkg::*;
#(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned SLOT_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cap_en,
  input  logic [SLOT_W-1:0]           cap_slot,
  input  logic [PORT_W-1:0]           cap_data,
  output logic [OPT_SLOTS*PORT_W-1:0] opt_flat
);
  for (genvar s = 0; s < OPT_SLOTS; s++) begin : g_slot
    logic [PORT_W-1:0] opt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        opt_q <= '0;
      end else if (cap_en && (cap_slot == SLOT_W'(s))) begin
        opt_q <= cap_data;
      end
    end
    assign opt_flat[s*PORT_W +: PORT_W] = opt_q;
  end
endmodule

// File: rtl/boot_port_map.sv
module boot_port_map
  import boot_opt_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input  logic [OPT_SLOTS*PORT_W-1:0] opt_flat,
  input  logic                        run,
  input  logic [PORT_W-1:0]           p1_sw_pu,
  output logic [PORT_W-1:0]           p0_pu,
  output logic [PORT_W-1:0]           p0_cmos,
  output logic [PORT_W-1:0]           p1_pu,
  output logic [PORT_W-1:0]           p1_cmos,
  output logic [PORT_W-1:0]           p7_pu,
  output logic                        port_hold
);
  logic [PORT_W-1:0] mode0, type1, pull7;

  assign mode0 = opt_flat[SLOT_P0*PORT_W +: PORT_W];
  assign type1 = opt_flat[SLOT_P1*PORT_W +: PORT_W];
  assign pull7 = opt_flat[SLOT_P7*PORT_W +: PORT_W];

  for (genvar b = 0; b < PORT_W; b++) begin : g_bit
    always_comb begin
      p0_pu[b]   = run & mode0[b];
      p0_cmos[b] = run & mode0[b];
      p1_cmos[b] = run & type1[b];
      p1_pu[b]   = run & p1_sw_pu[b];
      p7_pu[b]   = run & pull7[b];
    end
  end

  assign port_hold = ~run;
endmodule

// File: rtl/boot_opt_loader.sv
module boot_opt_loader
  import boot_opt_pkg::*;
#(
  parameter int unsigned WAIT_CYCLES = 16,
  parameter int unsigned ADDR_W      = 15,
  parameter int unsigned PORT_W      = 8,
  parameter logic [ADDR_W-1:0] OPT_BASE = 15'h7F00
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              rom_rd,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [PORT_W-1:0] rom_data,
  input  logic [PORT_W-1:0] p1_sw_pu,
  output logic [PORT_W-1:0] p0_pu,
  output logic [PORT_W-1:0] p0_cmos,
  output logic [PORT_W-1:0] p1_pu,
  output logic [PORT_W-1:0] p1_cmos,
  output logic [PORT_W-1:0] p7_pu,
  output logic              port_hold,
  output logic              cpu_run,
  output logic              load_done
);
  localparam int unsigned SLOT_W = $clog2(OPT_SLOTS);

  logic                        wait_en, wait_expired;
  logic                        cap_en;
  logic [SLOT_W-1:0]           cap_slot;
  logic [OPT_SLOTS*PORT_W-1:0] opt_flat;
  logic                        run;

  boot_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (wait_en),
    .expired  (wait_expired)
  );

  boot_fetch_seq #(
    .ADDR_W  (ADDR_W),
    .OPT_BASE(OPT_BASE),
    .SLOT_W  (SLOT_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .wait_expired (wait_expired),
    .wait_en      (wait_en),
    .rom_rd       (rom_rd),
    .rom_addr     (rom_addr),
    .cap_en       (cap_en),
    .cap_slot     (cap_slot),
    .run          (run),
    .done_pulse   (load_done)
  );

  boot_opt_regs #(.PORT_W(PORT_W), .SLOT_W(SLOT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .cap_slot (cap_slot),
    .cap_data (rom_data),
    .opt_flat (opt_flat)
  );

  boot_port_map #(.PORT_W(PORT_W)) u_map (
    .opt_flat  (opt_flat),
    .run       (run),
    .p1_sw_pu  (p1_sw_pu),
    .p0_pu     (p0_pu),
    .p0_cmos   (p0_cmos),
    .p1_pu     (p1_pu),
    .p1_cmos   (p1_cmos),
    .p7_pu     (p7_pu),
    .port_hold (port_hold)
  );

  assign cpu_run = run;
endmodule

// File: rtl/boot_opt_loader_chk.sv
module boot_opt_loader_chk #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned PORT_W = 8,
  parameter logic [ADDR_W-1:0] OPT_BASE = 15'h7F00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rom_rd,
  input logic [ADDR_W-1:0] rom_addr,
  input logic [PORT_W-1:0] p1_sw_pu,
  input logic [PORT_W-1:0] p0_pu,
  input logic [PORT_W-1:0] p0_cmos,
  input logic [PORT_W-1:0] p1_pu,
  input logic [PORT_W-1:0] p1_cmos,
  input logic [PORT_W-1:0] p7_pu,
  input logic              port_hold,
  input logic              cpu_run,
  input logic              load_done
);
  assert_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_run |-> (((p0_pu | p0_cmos | p1_pu | p1_cmos | p7_pu) == '0) && port_hold));

  assert_addr_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |-> ((rom_addr >= OPT_BASE) && (rom_addr <= OPT_BASE + ADDR_W'(2))));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_rd && $past(rom_rd)) |-> (rom_addr == $past(rom_addr) + ADDR_W'(1)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);

  assert_run_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_run |=> cpu_run);

  assert_run_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_run) |-> load_done);

  assert_no_late_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_run |-> !rom_rd);

  assert_sw_pull_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_run |-> (p1_pu == p1_sw_pu));
endmodule

bind boot_opt_loader boot_opt_loader_chk #(
  .ADDR_W(ADDR_W), .PORT_W(PORT_W), .OPT_BASE(OPT_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rom_rd(rom_rd), .rom_addr(rom_addr),
  .p1_sw_pu(p1_sw_pu), .p0_pu(p0_pu), .p0_cmos(p0_cmos), .p1_pu(p1_pu),
  .p1_cmos(p1_cmos), .p7_pu(p7_pu), .port_hold(port_hold),
  .cpu_run(cpu_run), .load_done(load_done)
);

// File: tb/boot_opt_loader_test.sv
`timescale 1ns/1ps
module boot_opt_loader_test;
  localparam int W = 16;
  localparam logic [14:0] BASE = 15'h7F00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rom_rd;
  logic [14:0] rom_addr;
  logic [7:0]  rom_data;
  logic [7:0]  p1_sw_pu = 8'h00;
  logic [7:0]  p0_pu, p0_cmos, p1_pu, p1_cmos, p7_pu;
  logic        port_hold, cpu_run, load_done;

  logic [7:0]  img0, img1, img2;
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;

  always #10 clk = ~clk;

  boot_opt_loader #(.WAIT_CYCLES(W)) uut (
    .clk(clk), .rst_n(rst_n), .rom_rd(rom_rd), .rom_addr(rom_addr),
    .rom_data(rom_data), .p1_sw_pu(p1_sw_pu), .p0_pu(p0_pu),
    .p0_cmos(p0_cmos), .p1_pu(p1_pu), .p1_cmos(p1_cmos), .p7_pu(p7_pu),
    .port_hold(port_hold), .cpu_run(cpu_run), .load_done(load_done)
  );

  // Memory model: one-cycle latency, junk on idle cycles
  always @(posedge clk) begin
    if (rom_rd) begin
      if (rom_addr == BASE)            rom_data <= img0;
      else if (rom_addr == BASE + 15'd1) rom_data <= img1;
      else if (rom_addr == BASE + 15'd2) rom_data <= img2;
      else                             rom_data <= 8'hA5 ^ rom_addr[7:0];
    end else begin
      rom_data <= 8'h5A;
    end
  end

  function automatic logic [7:0] exp_p0(input logic [7:0] b); return b; endfunction
  function automatic logic [7:0] exp_p1type(input logic [7:0] b); return b; endfunction
  function automatic logic [7:0] exp_p7(input logic [7:0] b); return b; endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_cleared(input string req);
    check(!cpu_run && !load_done && !rom_rd && port_hold &&
          ((p0_pu | p0_cmos | p1_pu | p1_cmos | p7_pu) == 8'h00),
          req, {cpu_run, load_done, rom_rd, port_hold}, 4'b0001);
  endtask

  // Runs one load; abort_k > 0 asserts reset at that negedge instead.
  task automatic run_load(input logic [7:0] b0, input logic [7:0] b1,
                          input logic [7:0] b2, input logic [7:0] sw_after,
                          input int abort_k);
    int rd_err = 0, seq_err = 0, run_err = 0, gate_err = 0;
    img0 = b0; img1 = b1; img2 = b2;
    p1_sw_pu = 8'hFF;
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_cleared("R1 reset state");
    rst_n = 1'b1;
    for (int k = 1; k <= W + 6; k++) begin
      @(negedge clk);
      if (abort_k == k) begin
        rst_n = 1'b0;
        #1;
        check_cleared("R10 reset mid-load clears");
        return;
      end
      if ((k >= W) && (k <= W + 2)) begin
        if (!rom_rd || rom_addr != BASE + 15'(k - W)) seq_err++;
      end else if (rom_rd) begin
        rd_err++;
      end
      if (cpu_run != (k >= W + 4) || load_done != (k == W + 4)) run_err++;
      if (k < W + 4 && (!port_hold ||
          ((p0_pu | p0_cmos | p1_pu | p1_cmos | p7_pu) != 8'h00))) gate_err++;
    end
    check(rd_err == 0, "R2/R11 read only in window (R2 R11)", rd_err, 0);
    check(seq_err == 0, "R3 address sequence", seq_err, 0);
    check(run_err == 0, "R9 run edge and done pulse", run_err, 0);
    check(gate_err == 0, "R8 pads gated before run", gate_err, 0);
    check(p0_pu == exp_p0(b0) && p0_cmos == exp_p0(b0), "R5 port 0 mode (R4 latency)",
          {p0_pu, p0_cmos}, {exp_p0(b0), exp_p0(b0)});
    check(p1_cmos == exp_p1type(b1), "R6 port 1 type (R4 latency)", p1_cmos, exp_p1type(b1));
    check(p7_pu == exp_p7(b2), "R7 port 7 pull-up (R4 latency)", p7_pu, exp_p7(b2));
    check(p1_pu == 8'hFF, "R6 sw pull-up passes when running", p1_pu, 8'hFF);
    p1_sw_pu = sw_after;
    #1;
    check(p1_pu == sw_after, "R6 sw pull-up follows", p1_pu, sw_after);
  endtask

  initial begin
    void'($urandom(32'd1234));
    img0 = 8'h00; img1 = 8'h00; img2 = 8'h00;
    run_load(8'h00, 8'h00, 8'h00, 8'h00, 0);
    run_load(8'hFF, 8'hFF, 8'hFF, 8'h0F, 0);
    run_load(8'hA5, 8'h3C, 8'h81, 8'h55, 0);
    // reset as the final byte is in flight, then a clean load
    run_load(8'hFF, 8'hFF, 8'hFF, 8'h00, W + 3);
    run_load(8'h12, 8'h34, 8'h56, 8'hAA, 0);
    // reset during wait phase, then restart with full wait (R10)
    run_load(8'hEE, 8'hEE, 8'hEE, 8'h00, 5);
    run_load(8'h0F, 8'hF0, 8'h99, 8'h33, 0);
    for (int i = 0; i < 6; i++) begin
      run_load(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 0);
    end
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule